// File: doc/BRIEF.md
# Dual-compare phase-offset timer

This block is an up-counting timer with two compare values. The first compare value, A, fixes the period: the counter runs 0, 1, ..., A and then wraps to 0, so one period spans A+1 count steps. The second compare value, B, marks a point inside every period. Each match raises a one-cycle interrupt request. The two matches also drive a set/reset output flag: an A match sets it and a B match clears it. The result is a square-ish output whose phase within the period is programmable.

Software programs A, B and a two-bit mode word through a simple write port. A mode word with the prime bit set and the run bit clear zeroes the counter and the output flag without counting. A mode word with both bits set then starts the count on the following clock edge. The counter steps either on every system clock, or once per rising edge of an external event line. That line passes through a two-stage synchronizer and an edge detector, so its level must stay stable for at least two system clocks. In practice this limits its rate to a quarter of the system clock.

Top module: `phase_timer`

## Requirements
- R1: Write port: when `wr_en` is 1 at a clock edge, `wr_sel`=0 loads compare A, 1 loads compare B, 2 loads the mode word (bit 0 = prime, bit 1 = run). After reset, compares, mode, `sr_out`, `irq_a` and `irq_b` are all 0.
- R2: A mode write with prime=1 and run=0 clears the counter to 0 and `sr_out` to 0 at that edge, and no count step or interrupt follows it.
- R3: After a mode write with prime=1 and run=1 at edge E, the first count step happens at edge E+1. No step happens at edge E itself.
- R4: The counter advances by one per count step and, on a step taken while it equals A, returns to 0. The period is A+1 steps.
- R5: A count step taken while the counter equals A makes `irq_a` high for exactly the next cycle. A step taken while it equals B does the same for `irq_b`.
- R6: `sr_out` goes to 1 at the same edge as an `irq_a` pulse and to 0 at the same edge as an `irq_b` pulse. Otherwise it holds.
- R7: B equal to all ones (-1) disables the B match. `irq_b` never pulses and `sr_out` is only ever set.
- R8: Counting runs only while both stored mode bits are 1. A mode write with run=0 and prime=0 freezes the counter and `sr_out` and suppresses both requests. A later prime=1, run=1 write resumes from the frozen count.
- R9: With `ext_sel`=1 the counter steps once per rising edge of `ext_evt`. A rise sampled at edge k steps the counter at edge k+2, and the resulting request is visible after that edge. The level of `ext_evt` must hold for at least two clocks.
- R10: `rst_n` clears the block asynchronously. Its release reaches the logic through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 compare A, 1 compare B, 2 mode |
| wr_data | input | CNT_W | Write data; mode uses bit 0 (prime) and bit 1 (run) |
| ext_sel | input | 1 | 1: count external events; 0: count system clocks |
| ext_evt | input | 1 | Asynchronous external event line |
| sr_out | output | 1 | Set/reset flag output |
| irq_a | output | 1 | One-cycle request on compare A match |
| irq_b | output | 1 | One-cycle request on compare B match |

## Verification
In internal-clock mode, the requests and the flag reflect the count value one edge earlier. After a run write at edge E, sample j (taken on the falling edge after E+j) therefore shows count value (o+j-1) mod (A+1), where o is the starting count. The bench computes every expected request and flag value from that formula and sweeps all A in 0..5 with every legal B, including -1. In event mode a request is due three falling-edge samples after the event line rises. The bench checks that exact sample for A=0, and elsewhere compares running request counts four cycles after each event. Stop and resume are checked from the sample after the stop edge onward, because the sample at that edge still shows the last step.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [1:0] {
    SEL_CMP_A = 2'd0,
    SEL_CMP_B = 2'd1,
    SEL_MODE  = 2'd2
  } wsel_e;

  localparam int MODE_PRIME_BIT = 0;
  localparam int MODE_RUN_BIT   = 1;
endpackage

// File: rtl/pt_cfg.sv
module pt_cfg
  import pt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cmp_a,
  output logic [CNT_W-1:0] cmp_b,
  output logic             run,
  output logic             prime_clr
);
  logic [CNT_W-1:0] cmp_a_q, cmp_a_d;
  logic [CNT_W-1:0] cmp_b_q, cmp_b_d;
  logic             prime_q, prime_d;
  logic             run_q, run_d;
  logic             mode_wr;

  always_comb begin
    mode_wr  = wr_en && (wr_sel == SEL_MODE);
    cmp_a_d  = cmp_a_q;
    cmp_b_d  = cmp_b_q;
    prime_d  = prime_q;
    run_d    = run_q;
    if (wr_en && (wr_sel == SEL_CMP_A)) cmp_a_d = wr_data;
    if (wr_en && (wr_sel == SEL_CMP_B)) cmp_b_d = wr_data;
    if (mode_wr) begin
      prime_d = wr_data[MODE_PRIME_BIT];
      run_d   = wr_data[MODE_RUN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_a_q <= '0;
      cmp_b_q <= '0;
      prime_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      cmp_a_q <= cmp_a_d;
      cmp_b_q <= cmp_b_d;
      prime_q <= prime_d;
      run_q   <= run_d;
    end
  end

  assign cmp_a     = cmp_a_q;
  assign cmp_b     = cmp_b_q;
  assign run       = prime_q & run_q;
  assign prime_clr = mode_wr & wr_data[MODE_PRIME_BIT] & ~wr_data[MODE_RUN_BIT];
endmodule

// File: rtl/pt_evt_sync.sv
module pt_evt_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_in,
  output logic evt_pulse
);
  logic [SYNC_STAGES:0] stage_q, stage_d;

  always_comb begin
    stage_d = {stage_q[SYNC_STAGES-1:0], evt_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign evt_pulse = stage_q[SYNC_STAGES-1] & ~stage_q[SYNC_STAGES];
endmodule

// File: rtl/pt_core.sv
module pt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  output logic             sr_out,
  output logic             irq_a,
  output logic             irq_b
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sr_q, sr_d;
  logic             irqa_q, irqa_d;
  logic             irqb_q, irqb_d;
  logic             hit_a, hit_b, b_live;

  always_comb begin
    b_live = (cmp_b != {CNT_W{1'b1}});
    hit_a  = tick && (cnt_q == cmp_a);
    hit_b  = tick && b_live && (cnt_q == cmp_b);

    cnt_d = cnt_q;
    if (clr)        cnt_d = '0;
    else if (hit_a) cnt_d = '0;
    else if (tick)  cnt_d = cnt_q + 1'b1;

    sr_d = sr_q;
    if (clr)        sr_d = 1'b0;
    else if (hit_a) sr_d = 1'b1;
    else if (hit_b) sr_d = 1'b0;

    irqa_d = hit_a && !clr;
    irqb_d = hit_b && !clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sr_q   <= 1'b0;
      irqa_q <= 1'b0;
      irqb_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sr_q   <= sr_d;
      irqa_q <= irqa_d;
      irqb_q <= irqb_d;
    end
  end

  assign sr_out = sr_q;
  assign irq_a  = irqa_q;
  assign irq_b  = irqb_q;

  // R4
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && (cnt_q == cmp_a)) |=> (cnt_q == '0));

  // R6
  set_on_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqa_q |-> sr_q);

  // R6
  clear_on_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqb_q |-> !sr_q);

  // R7
  no_b_when_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqb_q |-> ($past(cmp_b) != {CNT_W{1'b1}}));

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> ($stable(cnt_q) && $stable(sr_q)));

  // R8
  irq_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irqa_q || irqb_q) |-> $past(run));
endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ext_sel,
  input  logic             ext_evt,
  output logic             sr_out,
  output logic             irq_a,
  output logic             irq_b
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_sync_n;
  logic [CNT_W-1:0]      cmp_a, cmp_b;
  logic                  run, prime_clr, evt_pulse, tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[RST_STAGES-1];

  pt_cfg #(.CNT_W(CNT_W)) cfg_i (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cmp_a(cmp_a), .cmp_b(cmp_b), .run(run),
    .prime_clr(prime_clr)
  );

  pt_evt_sync #(.SYNC_STAGES(2)) sync_i (
    .clk(clk), .rst_n(rst_sync_n), .evt_in(ext_evt), .evt_pulse(evt_pulse)
  );

  assign tick = run && (ext_sel ? evt_pulse : 1'b1);

  pt_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .tick(tick), .clr(prime_clr),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .sr_out(sr_out), .irq_a(irq_a),
    .irq_b(irq_b)
  );

  // R9
  evt_step_only_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ext_sel && !evt_pulse) |=> !(irq_a || irq_b));
endmodule

// File: tb/phase_timer_tb_top.sv
module phase_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [15:0] wr_data;
  logic        ext_sel;
  logic        ext_evt;
  logic        sr_out, irq_a, irq_b;

  int checks = 0;
  int errors = 0;
  int na = 0;
  int nb = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  phase_timer #(.CNT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ext_sel(ext_sel), .ext_evt(ext_evt),
    .sr_out(sr_out), .irq_a(irq_a), .irq_b(irq_b)
  );

  always @(negedge clk) if (mon_on) begin
    na = na + int'(irq_a);
    nb = nb + int'(irq_b);
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_run(input int a, input int b, input int o, input int j,
                         inout logic srm);
    int  v;
    logic ea, eb;
    v  = (o + j - 1) % (a + 1);
    ea = (v == a);
    eb = (b >= 0) && (v == b) && !ea;
    if (ea) srm = 1'b1;
    else if (eb) srm = 1'b0;
    check(irq_a == ea, $sformatf("R5/R4/R3 irq_a A=%0d B=%0d j=%0d", a, b, j), irq_a, ea);
    check(irq_b == eb, $sformatf("R5/R7 irq_b A=%0d B=%0d j=%0d", a, b, j), irq_b, eb);
    check(sr_out == srm, $sformatf("R6 sr_out A=%0d B=%0d j=%0d", a, b, j), sr_out, srm);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic srm;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0;
    ext_sel = 1'b0; ext_evt = 1'b0;
    repeat (3) @(negedge clk);
    // R10 / R1: reset state
    check(sr_out == 1'b0, "R10 sr_out in reset", sr_out, 0);
    check(irq_a == 1'b0 && irq_b == 1'b0, "R1 irqs in reset", irq_a | irq_b, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sr_out == 1'b0, "R10 sr_out after release", sr_out, 0);

    // Sweep all A in 0..5 and legal B (including -1), internal clock
    for (int a = 0; a <= 5; a++) begin
      for (int b = -1; b < a; b++) begin
        wr(2'd0, 16'(a));
        wr(2'd1, 16'(b));
        wr(2'd2, 16'h0001);
        // R2: prime clears flag, no request
        check(sr_out == 1'b0, $sformatf("R2 sr_out after prime A=%0d", a), sr_out, 0);
        check(irq_a == 1'b0 && irq_b == 1'b0, "R2 irqs after prime", irq_a | irq_b, 0);
        wr(2'd2, 16'h0003);
        srm = 1'b0;
        for (int j = 1; j <= 3 * (a + 1) + 2; j++) begin
          @(negedge clk);
          chk_run(a, b, 0, j, srm);
        end
      end
    end

    // R8: stop and resume, A=5 B=2
    wr(2'd0, 16'd5);
    wr(2'd1, 16'd2);
    wr(2'd2, 16'h0001);
    wr(2'd2, 16'h0003);
    srm = 1'b0;
    for (int j = 1; j <= 8; j++) begin
      @(negedge clk);
      chk_run(5, 2, 0, j, srm);
    end
    wr(2'd2, 16'h0000);
    check(sr_out == 1'b0, "R8 sr_out at stop edge", sr_out, 0);
    for (int j = 1; j <= 10; j++) begin
      @(negedge clk);
      check(irq_a == 1'b0 && irq_b == 1'b0, "R8 irqs while stopped", irq_a | irq_b, 0);
      check(sr_out == 1'b0, "R8 sr_out held while stopped", sr_out, 0);
    end
    wr(2'd2, 16'h0003);
    srm = 1'b0;
    for (int j = 1; j <= 14; j++) begin
      @(negedge clk);
      chk_run(5, 2, 3, j, srm);
    end

    // R9: exact latency, event mode, A=0 B=-1
    ext_sel = 1'b1;
    wr(2'd0, 16'd0);
    wr(2'd1, 16'hFFFF);
    wr(2'd2, 16'h0001);
    wr(2'd2, 16'h0003);
    repeat (3) @(negedge clk);
    check(irq_a == 1'b0, "R9 no step without event", irq_a, 0);
    ext_evt = 1'b1;
    @(negedge clk);
    check(irq_a == 1'b0, "R9 irq_a sample 1 after rise", irq_a, 0);
    @(negedge clk);
    ext_evt = 1'b0;
    check(irq_a == 1'b0, "R9 irq_a sample 2 after rise", irq_a, 0);
    @(negedge clk);
    check(irq_a == 1'b1, "R9 irq_a sample 3 after rise", irq_a, 1);
    @(negedge clk);
    check(irq_a == 1'b0, "R9 irq_a sample 4 after rise", irq_a, 0);

    // R9: event counting, A=3 B=1, one step per rising edge
    wr(2'd0, 16'd3);
    wr(2'd1, 16'd1);
    wr(2'd2, 16'h0001);
    wr(2'd2, 16'h0003);
    repeat (2) @(negedge clk);
    na = 0; nb = 0; mon_on = 1'b1;
    for (int i = 0; i < 10; i++) begin
      int  ca, cb;
      logic se;
      ext_evt = 1'b1;
      repeat (2) @(negedge clk);
      ext_evt = 1'b0;
      repeat (2) @(negedge clk);
      #1;
      ca = 0; cb = 0; se = 1'b0;
      for (int t = 0; t <= i; t++) begin
        if (t % 4 == 3) begin ca++; se = 1'b1; end
        if (t % 4 == 1) begin cb++; se = 1'b0; end
      end
      check(na == ca, $sformatf("R9 irq_a count after event %0d", i), na, ca);
      check(nb == cb, $sformatf("R9 irq_b count after event %0d", i), nb, cb);
      check(sr_out == se, $sformatf("R9/R6 sr_out after event %0d", i), sr_out, se);
    end
    mon_on = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule